// File: doc/BRIEF.md
# Four-Channel Stepped-Frequency PWM Generator

This block drives four independent pulse-width-modulated outputs from one system clock. Each channel owns three settings: an 8-bit frequency code, an 8-bit duty code, and a polarity-invert bit. It also has an enable bit. The frequency code holds a 2-bit step selector and a 6-bit multiplier. The step picks a base rate in ratios of 1:4:16:64. The multiplier scales that base by (multiplier + 1).

Every period is cut into 256 duty slots. A per-channel fractional accumulator works out when the 256-slot phase counter moves on, so the average slot rate is exact even when the rate does not divide the clock.

Software programs the block through a plain parallel bus. A write uses an address, a data byte and a one-cycle strobe. A read supplies an address and gets the stored byte back one clock later. A write changes the waveform at once. The phase counter is not restarted, so the period in which a write lands can mix the old and new settings.

Top module: `pwm_stepped_bank`

## Requirements
- R1: After reset, all registers hold zero, every read returns zero and every output is low.
- R2: The frequency register for channel k sits at address 0x08+k. Bits [7:6] are the step s and bits [5:0] are the multiplier m. The period is 256*SLOT_DIV/((m+1)*4^s) clock cycles, and a non-integer period is met exactly on average. With the default SLOT_DIV of 4096, code 0xFF gives 256 cycles, 0xDF gives 512, 0xBF gives 1024 and 0x7F gives 4096.
- R3: The duty register for channel k sits at address 0x0C+k. A duty code d holds a non-inverted output high for (d+1)/256 of each period. Code 255 is constantly high.
- R4: The enable bit of channel k is bit 4+k of address 0x07. While it is clear, the channel output is constantly low whatever the invert bit holds.
- R5: The invert bit of channel k is bit k+2 of address 0x05. While the channel is enabled, this bit inverts the waveform.
- R6: Writes to any address other than 0x05, 0x07 and 0x08–0x0F change no output. Bits of 0x05 and 0x07 outside the channel fields change no output.
- R7: A read returns the byte stored at the read address on the clock after the address is presented. Unmapped addresses read as zero.
- R8: Frequency, duty and invert changes take effect on the next output update without restarting the phase counter.
- R9: Channels run independently. Settings of one channel do not alter another.
- R10: Enabling a channel starts its phase at slot 0. A non-inverted output is therefore high in the first cycle after the enable takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| pwm_out | output | NUM_CH | Registered PWM outputs, one per channel |

## Verification
A write is captured on the first clock edge. The output is recomputed from the new setting on the second edge, so the bench looks at outputs one falling edge after its write task returns. Read data is registered on the edge after the address is applied and is sampled on the next falling edge. Duty results are counted over windows exactly one period long, which makes the high count independent of where the window starts. Periods are measured between rising output edges. The fractional-rate case allows one cycle of slack over a three-period span.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int REG_W = 8;
  localparam int PHASE_W = 8;

  localparam logic [7:0] ADDR_INV   = 8'h05;
  localparam logic [7:0] ADDR_ENA   = 8'h07;
  localparam logic [7:0] ADDR_FREQ0 = 8'h08;
  localparam logic [7:0] ADDR_DUTY0 = 8'h0C;

  localparam int INV_BIT0 = 2;
  localparam int ENA_BIT0 = 4;

  typedef struct packed {
    logic                ena;
    logic                inv;
    logic [1:0]          step;
    logic [5:0]          mult;
    logic [PHASE_W-1:0]  duty;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [7:0]            rd_addr,
  output logic [REG_W-1:0]      rd_data,
  output chan_cfg_t [NUM_CH-1:0] cfg_o
);

  logic [REG_W-1:0] freq_q [NUM_CH];
  logic [REG_W-1:0] duty_q [NUM_CH];
  logic [REG_W-1:0] inv_q;
  logic [REG_W-1:0] ena_q;
  logic [REG_W-1:0] rd_next;
  logic [REG_W-1:0] rd_q;
  logic             wr_hit;

  always_comb begin
    wr_hit = (wr_addr == ADDR_INV) || (wr_addr == ADDR_ENA);
    for (int k = 0; k < NUM_CH; k++) begin
      if (wr_addr == ADDR_FREQ0 + 8'(k) || wr_addr == ADDR_DUTY0 + 8'(k)) wr_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q <= '0;
      ena_q <= '0;
      for (int k = 0; k < NUM_CH; k++) begin
        freq_q[k] <= '0;
        duty_q[k] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == ADDR_INV) inv_q <= wr_data;
      if (wr_addr == ADDR_ENA) ena_q <= wr_data;
      for (int k = 0; k < NUM_CH; k++) begin
        if (wr_addr == ADDR_FREQ0 + 8'(k)) freq_q[k] <= wr_data;
        if (wr_addr == ADDR_DUTY0 + 8'(k)) duty_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_INV) rd_next = inv_q;
    if (rd_addr == ADDR_ENA) rd_next = ena_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_addr == ADDR_FREQ0 + 8'(k)) rd_next = freq_q[k];
      if (rd_addr == ADDR_DUTY0 + 8'(k)) rd_next = duty_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cfg
    assign cfg_o[k].ena  = ena_q[ENA_BIT0 + k];
    assign cfg_o[k].inv  = inv_q[INV_BIT0 + k];
    assign cfg_o[k].step = freq_q[k][7:6];
    assign cfg_o[k].mult = freq_q[k][5:0];
    assign cfg_o[k].duty = duty_q[k];
  end

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_hit) && rd_addr == $past(wr_addr)) |=> rd_data == $past(wr_data, 2)); // R7

endmodule

// File: rtl/pwm_slot_div.sv
module pwm_slot_div #(
  parameter int SLOT_DIV = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] step_i,
  input  logic [5:0] mult_i,
  output logic       adv_o
);

  localparam int INC_W = 13;
  localparam int ACC_W = $clog2(SLOT_DIV) + 2;

  logic [INC_W-1:0] inc;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             hit;

  always_comb begin
    inc = INC_W'({1'b0, mult_i} + 7'd1) << {step_i, 1'b0};
    sum = acc_q + ACC_W'(inc);
    hit = sum >= ACC_W'(SLOT_DIV);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) acc_q <= '0;
    else if (hit)      acc_q <= sum - ACC_W'(SLOT_DIV);
    else               acc_q <= sum;
  end

  assign adv_o = run_i & hit;

  AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    acc_q < ACC_W'(SLOT_DIV)); // R2

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int SLOT_DIV = 4096
) (
  input  logic      clk,
  input  logic      rst,
  input  chan_cfg_t cfg,
  output logic      pwm_o
);

  logic               adv;
  logic [PHASE_W-1:0] phase_q;
  logic               pwm_q;

  pwm_slot_div #(.SLOT_DIV(SLOT_DIV)) i_div (
    .clk    (clk),
    .rst    (rst),
    .run_i  (cfg.ena),
    .step_i (cfg.step),
    .mult_i (cfg.mult),
    .adv_o  (adv)
  );

  always_ff @(posedge clk) begin
    if (rst || !cfg.ena) phase_q <= '0;
    else if (adv)        phase_q <= phase_q + PHASE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= cfg.ena & (cfg.inv ^ (phase_q <= cfg.duty));
  end

  assign pwm_o = pwm_q;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !cfg.ena |=> !pwm_o); // R4

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg.ena && !cfg.inv && cfg.duty == '1) |=> pwm_o); // R3

  AST_INVERTED_FULL_LOW: assert property (@(posedge clk) disable iff (rst)
    (cfg.ena && cfg.inv && cfg.duty == '1) |=> !pwm_o); // R5

endmodule

// File: rtl/pwm_stepped_bank.sv
module pwm_stepped_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SLOT_DIV = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] pwm_out
);

  chan_cfg_t [NUM_CH-1:0] cfg;

  pwm_regfile #(.NUM_CH(NUM_CH)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_o   (cfg)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan #(.SLOT_DIV(SLOT_DIV)) i_chan (
      .clk   (clk),
      .rst   (rst),
      .cfg   (cfg[k]),
      .pwm_o (pwm_out[k])
    );
  end

endmodule

// File: tb/test_pwm_stepped_bank.sv
module test_pwm_stepped_bank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_stepped_bank i_pwm_stepped_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(string req, string what, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic wait_rise(input int ch, output int waited);
    logic prev;
    prev = pwm_out[ch];
    waited = -1;
    for (int i = 1; i <= 20000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) begin
        waited = i;
        break;
      end
      prev = pwm_out[ch];
    end
  endtask

  task automatic period_of(input int ch, input int n, output int p);
    int w;
    wait_rise(ch, w);
    p = 0;
    for (int i = 0; i < n; i++) begin
      wait_rise(ch, w);
      p += w;
    end
  endtask

  task automatic t_reset();
    int v;
    check_eq("R1", "outputs after reset", int'(pwm_out), 0);
    rd(8'h05, v); check_eq("R1", "invert reg after reset", v, 0);
    rd(8'h07, v); check_eq("R1", "enable reg after reset", v, 0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h08 + 8'(k), v); check_eq("R1", "freq reg after reset", v, 0);
      rd(8'h0C + 8'(k), v); check_eq("R1", "duty reg after reset", v, 0);
    end
  endtask

  task automatic t_readback();
    int v;
    wr(8'h08, 8'hFF); wr(8'h0D, 8'h5A); wr(8'h0C, 8'd127); wr(8'h06, 8'hAA);
    rd(8'h08, v); check_eq("R7", "freq ch0 readback", v, 255);
    rd(8'h0D, v); check_eq("R7", "duty ch1 readback", v, 8'h5A);
    rd(8'h0C, v); check_eq("R7", "duty ch0 readback", v, 127);
    rd(8'h06, v); check_eq("R7", "unmapped address reads zero", v, 0);
  endtask

  task automatic t_disabled_invert();
    int h;
    wr(8'h05, 8'h3C);
    count_high(0, 300, h); check_eq("R4", "disabled ch0 with invert high count", h, 0);
    check_eq("R4", "all disabled outputs low", int'(pwm_out), 0);
    wr(8'h05, 8'h00);
  endtask

  task automatic t_duty();
    int h;
    wr(8'h07, 8'h10);
    @(negedge clk);
    check_eq("R10", "ch0 high right after enable", int'(pwm_out[0]), 1);
    count_high(0, 256, h); check_eq("R3", "duty 127 high slots", h, 128);
    wr(8'h0C, 8'd0); @(negedge clk);
    count_high(0, 256, h); check_eq("R3", "duty 0 high slots", h, 1);
    wr(8'h0C, 8'd255); @(negedge clk);
    count_high(0, 256, h); check_eq("R3", "duty 255 high slots", h, 256);
  endtask

  task automatic t_invert();
    int h;
    wr(8'h0C, 8'd63); wr(8'h05, 8'h04); @(negedge clk);
    count_high(0, 256, h); check_eq("R5", "inverted duty 63 high slots", h, 192);
    wr(8'h05, 8'h00); @(negedge clk);
    count_high(0, 256, h); check_eq("R5", "invert cleared duty 63 high slots", h, 64);
  endtask

  task automatic t_freq();
    int p;
    int h;
    wr(8'h0C, 8'd127);
    period_of(0, 1, p); check_eq("R2", "period code 0xFF", p, 256);
    wr(8'h08, 8'hDF); period_of(0, 1, p); check_eq("R2", "period code 0xDF", p, 512);
    wr(8'h0C, 8'd63); @(negedge clk);
    count_high(0, 512, h); check_eq("R2", "code 0xDF duty 63 high cycles", h, 128);
    wr(8'h0C, 8'd127);
    wr(8'h08, 8'hBF); period_of(0, 1, p); check_eq("R2", "period code 0xBF", p, 1024);
    wr(8'h08, 8'h7F); period_of(0, 1, p); check_eq("R2", "period code 0x7F", p, 4096);
    wr(8'h08, 8'hC2); period_of(0, 3, p);
    check_rng("R2", "three periods code 0xC2 (fractional)", p, 16383, 16385);
  endtask

  task automatic t_immediate();
    int w;
    int k;
    wr(8'h08, 8'hFF); wr(8'h0C, 8'd127);
    wait_rise(0, w);
    k = 0;
    repeat (100) begin @(negedge clk); k++; end
    wr(8'h0C, 8'd63); k++;
    @(negedge clk); k++;
    check_eq("R8", "output drops right after duty cut", int'(pwm_out[0]), 0);
    wait_rise(0, w);
    check_eq("R8", "period kept across duty write", k + w, 256);
  endtask

  task automatic t_ignored();
    int h;
    int v;
    wr(8'h0C, 8'd63);
    wr(8'h06, 8'hFF); wr(8'h04, 8'hFF); wr(8'h10, 8'hFF); wr(8'hFF, 8'hFF);
    wr(8'h07, 8'h1F); wr(8'h05, 8'hC3); @(negedge clk);
    count_high(0, 256, h); check_eq("R6", "ch0 high slots after stray writes", h, 64);
    check_eq("R6", "other channels stay low", int'(pwm_out[3:1]), 0);
    rd(8'h10, v); check_eq("R6", "address 0x10 stays empty", v, 0);
    wr(8'h05, 8'h00); wr(8'h07, 8'h10);
  endtask

  task automatic t_channels();
    int h0;
    int h1;
    wr(8'h08, 8'hFF); wr(8'h0C, 8'd127);
    wr(8'h09, 8'hDF); wr(8'h0D, 8'd63);
    wr(8'h07, 8'h30); @(negedge clk);
    h0 = 0; h1 = 0;
    repeat (512) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
    check_eq("R9", "ch0 high cycles in 512", h0, 256);
    check_eq("R9", "ch1 high cycles in 512", h1, 128);
    wr(8'h07, 8'h20); @(negedge clk);
    h0 = 0; h1 = 0;
    repeat (512) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
    check_eq("R9", "ch0 disabled high cycles", h0, 0);
    check_eq("R9", "ch1 unaffected by ch0 disable", h1, 128);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_disabled_invert();
    t_duty();
    t_invert();
    t_freq();
    t_immediate();
    t_ignored();
    t_channels();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule